// File: doc/BRIEF.md
# Time-Match Alarm Unit with Maskable Fields and Interrupt Routing

This block holds two alarm register sets. Each set has four bytes: seconds, minutes, hours and day of week. On every one-second rollover pulse from the timekeeping logic, each set is compared against the current time. When every field that is not masked matches, a per-alarm pending flag is raised. Setting the top bit of an alarm byte turns that field into a wildcard.

The pending flags drive two active-low interrupt outputs through per-alarm enable bits and a routing bit. The routing bit selects one of two arrangements. In the first, both alarms share interrupt 0. In the second, alarm 1 has interrupt 1 to itself. Software can clear a flag in two ways: by writing a zero into its status bit, or by reading any byte of that alarm's register set. A flag is raised whether or not its enable is set, so the alarm can also be polled.

The block decodes only its own small register window. Every register access is a single-cycle strobe with no back-pressure. A write takes effect at the clock edge where `wr_en` is high. Read data appears on `rd_data` one cycle after the `rd_en` strobe and holds until the next read.

Top module: `tmatch_alarm`

## Requirements
- R1: After reset, both pending flags are 0, both interrupt outputs are high, and the alarm, control and status registers all read as 0x00.
- R2: The registers are laid out as follows, and written bytes read back unchanged on `rd_data` one cycle after `rd_en`.
  - Alarm 0 occupies 0x07 to 0x0A and alarm 1 occupies 0x0B to 0x0E, each in the order seconds, minutes, hours, day of week.
  - Control is at 0x0F: bit 0 is the alarm 0 enable, bit 1 the alarm 1 enable, and bit 2 the routing bit. Its other bits read 0.
  - Status is at 0x10: bit 0 holds the alarm 0 flag and bit 1 the alarm 1 flag.
  - Any other address reads 0x00.
- R3: A pending flag never becomes set in a cycle without `sec_tick`, even when the current time matches.
- R4: When `sec_tick` is high, an alarm's flag is set if every field whose bit 7 is 0 equals bits 6:0 of the matching current-time input. Bit 7 of the current-time inputs is ignored.
- R5: An alarm byte with bit 7 set always matches. A set with all four fields masked raises its flag on every tick.
- R6: Reading any byte of an alarm's register set clears that alarm's flag and leaves the other alarm's flag unchanged.
- R7: A write to status clears flag k when data bit k is 0. Flag k is left unchanged when data bit k is 1.
- R8: When a match on a tick and a clear (by read or status write) fall in the same cycle, the flag ends set.
- R9: A flag is raised and visible in status even while its enable bit is 0.
- R10: `irq0_n` is low exactly when either of these holds: (alarm 0 flag AND enable 0), or (routing bit = 0 AND alarm 1 flag AND enable 1).
- R11: `irq1_n` is low exactly when the routing bit is 1, the alarm 1 flag is set and enable 1 is set. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse at each seconds rollover |
| now_sec | input | 8 | Current seconds (BCD) |
| now_min | input | 8 | Current minutes (BCD) |
| now_hour | input | 8 | Current hours (encoded byte) |
| now_wday | input | 8 | Current day of week |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq0_n | output | 1 | Interrupt 0, active low |
| irq1_n | output | 1 | Interrupt 1, active low |

## Verification
The assertions check several rules on every cycle:
- a flag rises only after a tick;
- a tick with a full match leaves the flag set, including against a clear in the same cycle;
- a read or status clear without a competing match leaves the flag low;
- interrupt 1 stays high while the routing bit is 0.

Only the bench scenarios can show the routing and enable combinations, the register readback, and the polled flag with its enable off. The same applies to wildcard fields met by random current-time values with the top bit set.

// File: rtl/tma_pkg.sv
package tma_pkg;
  localparam int DW       = 8;
  localparam int AW       = 5;
  localparam int NFLD     = 4;
  localparam int NALM     = 2;
  localparam int FW       = $clog2(NFLD);
  localparam int AIW      = (NALM > 1) ? $clog2(NALM) : 1;
  localparam int MASK_BIT = DW - 1;
  localparam int CTRL_W   = NALM + 1;

  localparam logic [AW-1:0] ALM_BASE  = AW'(7);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(15);
  localparam logic [AW-1:0] STAT_ADDR = AW'(16);

  typedef logic [DW-1:0]           byte_t;
  typedef byte_t [NFLD-1:0]        fields_t;

  typedef struct packed {
    logic            route;
    logic [NALM-1:0] en;
  } ctrl_t;
endpackage

// File: rtl/tma_field_cmp.sv
module tma_field_cmp
  import tma_pkg::*;
(
  input  byte_t alm,
  input  byte_t now,
  output logic  hit
);
  always_comb hit = alm[MASK_BIT] | (alm[MASK_BIT-1:0] == now[MASK_BIT-1:0]);
endmodule

// File: rtl/tma_alarm_set.sv
module tma_alarm_set
  import tma_pkg::*;
#(
  parameter logic [tma_pkg::AW-1:0] BASE = tma_pkg::ALM_BASE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  fields_t       now,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  byte_t         wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          stat_clr,
  output fields_t       regs,
  output logic          flag
);
  logic [AW-1:0]   woff, roff;
  logic            wr_hit, rd_hit, all_hit;
  logic [NFLD-1:0] fld_hit;

  always_comb begin
    woff   = wr_addr - BASE;
    roff   = rd_addr - BASE;
    wr_hit = wr_en && (wr_addr >= BASE) && (woff < AW'(NFLD));
    rd_hit = rd_en && (rd_addr >= BASE) && (roff < AW'(NFLD));
  end

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    tma_field_cmp u_cmp (
      .alm (regs[f]),
      .now (now[f]),
      .hit (fld_hit[f])
    );
  end

  assign all_hit = &fld_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_hit) begin
      regs[woff[FW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (tick && all_hit) begin
      flag <= 1'b1;
    end else if (rd_hit || stat_clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tma_irq_route.sv
module tma_irq_route
  import tma_pkg::*;
(
  input  logic [NALM-1:0] flags,
  input  ctrl_t           ctrl,
  output logic            irq0_n,
  output logic            irq1_n
);
  logic [NALM-1:0] live;

  always_comb begin
    live   = flags & ctrl.en;
    irq0_n = ~(live[0] | (live[1] & ~ctrl.route));
    irq1_n = ~(live[1] & ctrl.route);
  end
endmodule

// File: rtl/tmatch_alarm.sv
module tmatch_alarm
  import tma_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sec_tick,
  input  logic [tma_pkg::DW-1:0] now_sec,
  input  logic [tma_pkg::DW-1:0] now_min,
  input  logic [tma_pkg::DW-1:0] now_hour,
  input  logic [tma_pkg::DW-1:0] now_wday,
  input  logic                  wr_en,
  input  logic [tma_pkg::AW-1:0] wr_addr,
  input  logic [tma_pkg::DW-1:0] wr_data,
  input  logic                  rd_en,
  input  logic [tma_pkg::AW-1:0] rd_addr,
  output logic [tma_pkg::DW-1:0] rd_data,
  output logic                  irq0_n,
  output logic                  irq1_n
);
  fields_t                now;
  fields_t [NALM-1:0]     alm_regs;
  logic    [NALM-1:0]     flags;
  logic    [NALM-1:0]     stat_clr;
  ctrl_t                  ctrl;
  logic                   stat_wr;
  logic    [AW-1:0]       roff;
  byte_t                  rd_next;

  assign now     = {now_wday, now_hour, now_min, now_sec};
  assign stat_wr = wr_en && (wr_addr == STAT_ADDR);

  for (genvar k = 0; k < NALM; k++) begin : g_alm
    assign stat_clr[k] = stat_wr && !wr_data[k];

    tma_alarm_set #(
      .BASE (ALM_BASE + AW'(k * NFLD))
    ) u_set (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sec_tick),
      .now      (now),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .stat_clr (stat_clr[k]),
      .regs     (alm_regs[k]),
      .flag     (flags[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en && (wr_addr == CTRL_ADDR)) begin
      ctrl <= wr_data[CTRL_W-1:0];
    end
  end

  always_comb begin
    roff    = rd_addr - ALM_BASE;
    rd_next = '0;
    if ((rd_addr >= ALM_BASE) && (roff < AW'(NALM * NFLD))) begin
      rd_next = alm_regs[roff[FW+AIW-1:FW]][roff[FW-1:0]];
    end else if (rd_addr == CTRL_ADDR) begin
      rd_next = DW'(ctrl);
    end else if (rd_addr == STAT_ADDR) begin
      rd_next = DW'(flags);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
    end
  end

  tma_irq_route u_route (
    .flags  (flags),
    .ctrl   (ctrl),
    .irq0_n (irq0_n),
    .irq1_n (irq1_n)
  );
endmodule

// File: rtl/tma_checker.sv
module tma_checker
  import tma_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input fields_t            now,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input byte_t              wr_data,
  input logic               rd_en,
  input logic [AW-1:0]      rd_addr,
  input fields_t [NALM-1:0] alm_regs,
  input logic [NALM-1:0]    flags,
  input logic               route,
  input logic               irq0_n,
  input logic               irq1_n
);
  function automatic logic set_matches(input fields_t a, input fields_t t);
    logic ok = 1'b1;
    for (int f = 0; f < NFLD; f++)
      if (!a[f][MASK_BIT] && (a[f][MASK_BIT-1:0] != t[f][MASK_BIT-1:0])) ok = 1'b0;
    return ok;
  endfunction

  logic mt0, mt1, rd0, clr0;
  always_comb begin
    mt0  = tick && set_matches(alm_regs[0], now);
    mt1  = tick && set_matches(alm_regs[1], now);
    rd0  = rd_en && (rd_addr >= ALM_BASE) && (rd_addr < ALM_BASE + AW'(NFLD));
    clr0 = wr_en && (wr_addr == STAT_ADDR) && !wr_data[0];
  end

  a_r3_rise0_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(tick));
  a_r3_rise1_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(tick));
  a_r4_match_sets0: assert property (@(posedge clk) disable iff (!rst_n)
    mt0 |=> flags[0]);
  a_r4_match_sets1: assert property (@(posedge clk) disable iff (!rst_n)
    mt1 |=> flags[1]);
  a_r6_read_clears0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && !mt0) |=> !flags[0]);
  a_r7_stat_clears0: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0 && !mt0) |=> !flags[0]);
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mt0 && (rd0 || clr0)) |=> flags[0]);
  a_r10_idle_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> (irq0_n && irq1_n));
  a_r11_shared_keeps_irq1: assert property (@(posedge clk) disable iff (!rst_n)
    !route |-> irq1_n);
endmodule

bind tmatch_alarm tma_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (sec_tick),
  .now      (now),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .alm_regs (alm_regs),
  .flags    (flags),
  .route    (ctrl.route),
  .irq0_n   (irq0_n),
  .irq1_n   (irq1_n)
);

// File: tb/tmatch_alarm_test.sv
module tmatch_alarm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq0_n, irq1_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_alm [8];
  logic [2:0] m_ctrl;
  logic [1:0] m_flag;
  logic [7:0] m_rd;

  always #10 clk = ~clk;

  tmatch_alarm uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_wday(now_wday),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq0_n(irq0_n), .irq1_n(irq1_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic exp_match(input int k, input logic [7:0] t [4]);
    logic ok = 1'b1;
    for (int f = 0; f < 4; f++) begin
      logic [7:0] b = m_alm[k*4+f];
      if (!b[7] && (b[6:0] != t[f][6:0])) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    if (a >= 5'd7 && a <= 5'd14) return m_alm[a-7];
    if (a == 5'd15) return {5'b0, m_ctrl};
    if (a == 5'd16) return {6'b0, m_flag};
    return 8'h00;
  endfunction

  task automatic step(input logic tk, input logic [7:0] s, input logic [7:0] mi,
                      input logic [7:0] h, input logic [7:0] w,
                      input logic we, input logic [4:0] wa, input logic [7:0] wd,
                      input logic re, input logic [4:0] ra);
    logic [7:0] t [4];
    logic [1:0] nf;
    @(negedge clk);
    sec_tick = tk; now_sec = s; now_min = mi; now_hour = h; now_wday = w;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(posedge clk);
    t[0] = s; t[1] = mi; t[2] = h; t[3] = w;
    nf = m_flag;
    for (int k = 0; k < 2; k++) begin
      if (re && ra >= 5'(7 + 4*k) && ra < 5'(11 + 4*k)) nf[k] = 1'b0;
      if (we && wa == 5'd16 && !wd[k]) nf[k] = 1'b0;
      if (tk && exp_match(k, t)) nf[k] = 1'b1;
    end
    if (re) m_rd = exp_read(ra);
    if (we && wa >= 5'd7 && wa <= 5'd14) m_alm[wa-7] = wd;
    if (we && wa == 5'd15) m_ctrl = wd[2:0];
    m_flag = nf;
    #2;
    chk("R10 irq0_n", {7'b0, irq0_n}, {7'b0, !((m_flag[0] & m_ctrl[0]) |
                                              (!m_ctrl[2] & m_flag[1] & m_ctrl[1]))});
    chk("R11 irq1_n", {7'b0, irq1_n}, {7'b0, !(m_ctrl[2] & m_flag[1] & m_ctrl[1])});
    if (re) chk("R2 rd_data", rd_data, m_rd);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, a, d, 1'b0, 5'd0);
  endtask

  task automatic rd(input logic [4:0] a);
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 5'd0, 8'h00, 1'b1, a);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1D0C_4A11));
    for (int i = 0; i < 8; i++) m_alm[i] = 8'h00;
    m_ctrl = '0; m_flag = '0; m_rd = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset irq0_n", {7'b0, irq0_n}, 8'h01);
    chk("R1 reset irq1_n", {7'b0, irq1_n}, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    rd(5'd16); chk("R1 status after reset", rd_data, 8'h00);
    rd(5'd8);  chk("R1 alarm byte after reset", rd_data, 8'h00);

    wr(5'd7, 8'h10); wr(5'd8, 8'h20); wr(5'd9, 8'h05); wr(5'd10, 8'h03);
    wr(5'd15, 8'h01);
    rd(5'd9); chk("R2 alarm0 hour readback", rd_data, 8'h05);

    step(1'b1, 8'h10, 8'h21, 8'h05, 8'h03, 1'b0, 5'd0, 8'h00, 1'b0, 5'd0);
    chk("R4 minute mismatch no flag", {7'b0, irq0_n}, 8'h01);
    step(1'b1, 8'h90, 8'h20, 8'h05, 8'h03, 1'b0, 5'd0, 8'h00, 1'b0, 5'd0);
    chk("R4 full match asserts irq0", {7'b0, irq0_n}, 8'h00);
    wr(5'd16, 8'h00);
    chk("R7 status zero clears", {7'b0, irq0_n}, 8'h01);
    step(1'b0, 8'h10, 8'h20, 8'h05, 8'h03, 1'b0, 5'd0, 8'h00, 1'b0, 5'd0);
    chk("R3 no tick no flag", {7'b0, irq0_n}, 8'h01);
    step(1'b1, 8'h10, 8'h20, 8'h05, 8'h03, 1'b0, 5'd0, 8'h00, 1'b0, 5'd0);
    wr(5'd16, 8'h01);
    chk("R7 status one keeps flag", {7'b0, irq0_n}, 8'h00);

    wr(5'd11, 8'h80); wr(5'd12, 8'h80); wr(5'd13, 8'h80); wr(5'd14, 8'h80);
    step(1'b1, 8'h44, 8'h33, 8'h12, 8'h06, 1'b0, 5'd0, 8'h00, 1'b0, 5'd0);
    rd(5'd16); chk("R9 R5 masked alarm1 flag with enable off", rd_data, 8'h03);
    rd(5'd7);  chk("R2 alarm0 sec readback", rd_data, 8'h10);
    rd(5'd16); chk("R6 alarm0 read clears only flag0", rd_data, 8'h02);
    chk("R10 irq0 high, enables gate flag1", {7'b0, irq0_n}, 8'h01);

    wr(5'd15, 8'h02);
    chk("R10 shared line carries alarm1", {7'b0, irq0_n}, 8'h00);
    chk("R11 irq1 idle when shared", {7'b0, irq1_n}, 8'h01);
    wr(5'd15, 8'h06);
    chk("R11 routed alarm1 on irq1", {7'b0, irq1_n}, 8'h00);
    chk("R10 irq0 released when routed", {7'b0, irq0_n}, 8'h01);

    step(1'b1, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1, 5'd16, 8'h00, 1'b0, 5'd0);
    chk("R8 match beats status clear", {7'b0, irq1_n}, 8'h00);
    step(1'b1, 8'h01, 8'h02, 8'h03, 8'h04, 1'b0, 5'd0, 8'h00, 1'b1, 5'd12);
    chk("R8 match beats read clear", {7'b0, irq1_n}, 8'h00);
    rd(5'd15); chk("R2 control readback", rd_data, 8'h06);
    rd(5'd3);  chk("R2 unmapped address reads zero", rd_data, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] tv [4];
      logic       we, re, tk;
      logic [4:0] wa, ra;
      logic [7:0] wd;
      for (int f = 0; f < 4; f++) tv[f] = {1'($urandom), 5'b0, 2'($urandom)};
      tk = ($urandom % 3) == 0;
      we = ($urandom % 3) == 0;
      re = ($urandom % 3) == 0;
      wa = ($urandom % 8 == 0) ? 5'($urandom) : 5'(7 + $urandom % 10);
      ra = ($urandom % 8 == 0) ? 5'($urandom) : 5'(7 + $urandom % 10);
      wd = (wa == 5'd16 || wa == 5'd15) ? 8'($urandom)
           : {($urandom % 4 == 0), 5'b0, 2'($urandom)};
      step(tk, tv[0], tv[1], tv[2], tv[3], we, wa, wd, re, ra);
    end
    finish_run();
  end
endmodule